// File: doc/BRIEF.md
# FSK Frame Decoder

The decoder takes the digitized output of a carrier comparator, sampled on a reference clock that runs at the field frequency. It times each carrier cycle from one rising edge to the next. A period near 8 clocks is classed as a short symbol, and a period near 10 clocks is classed as a long symbol. A run of equal symbols then becomes a number of data bits. Short cycles carry 0 and are grouped by seven. Long cycles carry 1 and are grouped by six.

The recovered bit stream is searched for a header made of nine 0 bits and then one 1 bit. Once the header is found, 64 bits are captured, counted from the first header bit. The frame is presented as two 32-bit words, together with three sub-fields cut from fixed bit offsets, and a one-clock strobe marks each new frame. When single-capture mode is selected, the decoder stops after its first frame and stays stopped until it is restarted.

Top module: `fsk_frame_decoder`

## Requirements
- R1: A carrier period of 7 or 8 clocks is a short symbol (bit 0), and a period of 9, 10 or 11 clocks is a long symbol (bit 1). Any other period drops the run in progress and any partial frame, and the header search starts again.
- R2: A run of equal symbols is turned into bits when a symbol of the other class ends. The bit count is the run length divided by 7 for short runs or by 6 for long runs, rounded to the nearest integer with halves rounded up.
- R3: A run of more than 64 cycles is counted as 64 cycles. For example, 70 short cycles give 9 zero bits.
- R4: A frame starts when the last ten bits received since the last restart of the search are 0000000001. The frame is 64 bits long, and its bit 0 is the first header bit.
- R5: `word_hi_o` holds frame bits 0 to 31 and `word_lo_o` holds frame bits 32 to 63. In each word the earlier bit is the more significant one.
- R6: `version_o` is frame bits 14 to 17, `tag_o` is frame bits 19 to 26, and `number_o` is frame bits 36 to 44. In each field the earliest bit is the most significant one.
- R7: `valid_o` is high for exactly one clock for each captured frame. All frame outputs keep their values until the next capture.
- R8: `valid_o` goes high 3 clocks after the rising carrier edge that ends the first cycle of the run after the frame's last run.
- R9: If `single_i` is high when a frame completes, `done_o` goes high together with `valid_o`. Later input is then ignored until `restart_i`, which clears `done_o` and restarts the header search.
- R10: While reset is held and just after it is released, `valid_o` and `done_o` are low and all frame outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock at the field frequency |
| rst_ni | input | 1 | Asynchronous reset, active low |
| carrier_i | input | 1 | Digitized carrier comparator output |
| single_i | input | 1 | Stop after the first decoded frame |
| restart_i | input | 1 | Leave the stopped state and restart the header search |
| valid_o | output | 1 | One-clock strobe for a new frame |
| done_o | output | 1 | A frame was captured in single-capture mode |
| word_hi_o | output | 32 | Frame bits 0 to 31 |
| word_lo_o | output | 32 | Frame bits 32 to 63 |
| version_o | output | 4 | Frame bits 14 to 17 |
| tag_o | output | 8 | Frame bits 19 to 26 |
| number_o | output | 9 | Frame bits 36 to 44 |

## Verification
The frame's last run cannot be turned into bits until a cycle of the other class has ended. The frame outputs therefore appear exactly 3 clocks after the rising edge that ends the first cycle of that following run: one clock for period timing, one for run grouping and one for capture. The bench drives every carrier edge itself and records the clock index of that particular rise. It samples the outputs on the falling edge and requires the strobe on exactly that index plus three, with one strobe per frame. `done_o` is checked on the strobe cycle itself, and held outputs are checked after later frames that were ignored or aborted.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
  localparam int FRAME_W = 64;
  localparam int WORD_W  = 32;
  localparam int HDR_W   = 10;
  localparam logic [HDR_W-1:0] HDR_PAT = 10'b00_0000_0001;
  localparam int VER_OFF = 14;
  localparam int VER_W   = 4;
  localparam int TAG_OFF = 19;
  localparam int TAG_W   = 8;
  localparam int NUM_OFF = 36;
  localparam int NUM_W   = 9;

  typedef enum logic [1:0] {SYM_SHORT, SYM_LONG, SYM_BAD} sym_e;
  typedef enum logic [1:0] {ST_HUNT, ST_CAPT, ST_DONE} st_e;
endpackage

// File: rtl/fsk_period_meter.sv
module fsk_period_meter
  import fsk_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int SHORT_MIN = 7,
  parameter int SHORT_MAX = 8,
  parameter int LONG_MIN  = 9,
  parameter int LONG_MAX  = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carrier_i,
  output logic sym_v_o,
  output sym_e sym_o
);
  localparam logic [CNT_W-1:0] S_LO = CNT_W'(SHORT_MIN);
  localparam logic [CNT_W-1:0] S_HI = CNT_W'(SHORT_MAX);
  localparam logic [CNT_W-1:0] L_LO = CNT_W'(LONG_MIN);
  localparam logic [CNT_W-1:0] L_HI = CNT_W'(LONG_MAX);

  logic             car_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rise;
  sym_e             cls;

  assign rise = carrier_i & ~car_q;

  always_comb begin
    if (cnt_q >= S_LO && cnt_q <= S_HI)      cls = SYM_SHORT;
    else if (cnt_q >= L_LO && cnt_q <= L_HI) cls = SYM_LONG;
    else                                     cls = SYM_BAD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q   <= 1'b0;
      cnt_q   <= '0;
      sym_v_o <= 1'b0;
      sym_o   <= SYM_BAD;
    end else begin
      car_q   <= carrier_i;
      sym_v_o <= rise;
      if (rise) begin
        sym_o <= cls;
        cnt_q <= CNT_W'(1);
      end else if (cnt_q != '1) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/fsk_run_binner.sv
module fsk_run_binner
  import fsk_pkg::*;
#(
  parameter int GRP0    = 7,
  parameter int GRP1    = 6,
  parameter int MAX_RUN = 64,
  parameter int NB_W    = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sym_v_i,
  input  sym_e            sym_i,
  output logic            bits_v_o,
  output logic [NB_W-1:0] bits_n_o,
  output logic            bits_val_o,
  output logic            abort_o
);
  localparam int RUN_W = $clog2(MAX_RUN + 1);
  localparam int DIV_W = RUN_W + 2;

  logic             cls_q;
  logic [RUN_W-1:0] run_q;
  logic             new_cls;
  logic [DIV_W-1:0] num0, num1, n_round;

  assign new_cls = (sym_i == SYM_LONG);
  // round half up: (2*run + g) / (2*g)
  assign num0    = {1'b0, run_q, 1'b0} + DIV_W'(GRP0);
  assign num1    = {1'b0, run_q, 1'b0} + DIV_W'(GRP1);
  assign n_round = cls_q ? (num1 / DIV_W'(2 * GRP1)) : (num0 / DIV_W'(2 * GRP0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cls_q      <= 1'b0;
      run_q      <= '0;
      bits_v_o   <= 1'b0;
      bits_n_o   <= '0;
      bits_val_o <= 1'b0;
      abort_o    <= 1'b0;
    end else begin
      bits_v_o <= 1'b0;
      abort_o  <= 1'b0;
      if (sym_v_i) begin
        if (sym_i == SYM_BAD) begin
          run_q   <= '0;
          abort_o <= 1'b1;
        end else if (run_q != '0 && new_cls == cls_q) begin
          if (run_q != RUN_W'(MAX_RUN)) run_q <= run_q + RUN_W'(1);
        end else begin
          if (run_q != '0) begin
            bits_v_o   <= 1'b1;
            bits_n_o   <= NB_W'(n_round);
            bits_val_o <= cls_q;
          end
          cls_q <= new_cls;
          run_q <= RUN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fsk_frame_capture.sv
module fsk_frame_capture
  import fsk_pkg::*;
#(
  parameter int MAX_BITS = 11,
  parameter int NB_W     = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bits_v_i,
  input  logic [NB_W-1:0]    bits_n_i,
  input  logic               bits_val_i,
  input  logic               abort_i,
  input  logic               single_i,
  input  logic               restart_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic               valid_o,
  output logic               done_o
);
  localparam int FILL_W = $clog2(FRAME_W + 1);

  st_e                st_q, st_d;
  logic [FRAME_W-1:0] sh_q, sh_d, frame_d;
  logic [FILL_W-1:0]  fill_q, fill_d;
  logic               emit;

  always_comb begin
    st_d    = st_q;
    sh_d    = sh_q;
    fill_d  = fill_q;
    frame_d = frame_o;
    emit    = 1'b0;
    if (restart_i) begin
      st_d   = ST_HUNT;
      fill_d = '0;
    end else if (st_q != ST_DONE) begin
      if (abort_i) begin
        st_d   = ST_HUNT;
        fill_d = '0;
      end else if (bits_v_i) begin
        // apply up to MAX_BITS identical bits in one cycle
        for (int i = 0; i < MAX_BITS; i++) begin
          if (NB_W'(i) < bits_n_i && st_d != ST_DONE) begin
            sh_d = {sh_d[FRAME_W-2:0], bits_val_i};
            if (st_d == ST_HUNT) begin
              if (fill_d != FILL_W'(HDR_W)) fill_d = fill_d + FILL_W'(1);
              if (fill_d == FILL_W'(HDR_W) && sh_d[HDR_W-1:0] == HDR_PAT) st_d = ST_CAPT;
            end else begin
              fill_d = fill_d + FILL_W'(1);
              if (fill_d == FILL_W'(FRAME_W)) begin
                emit    = 1'b1;
                frame_d = sh_d;
                fill_d  = '0;
                st_d    = single_i ? ST_DONE : ST_HUNT;
              end
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_HUNT;
      sh_q    <= '0;
      fill_q  <= '0;
      frame_o <= '0;
      valid_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      sh_q    <= sh_d;
      fill_q  <= fill_d;
      frame_o <= frame_d;
      valid_o <= emit;
    end
  end

  assign done_o = (st_q == ST_DONE);
endmodule

// File: rtl/fsk_frame_decoder.sv
module fsk_frame_decoder
  import fsk_pkg::*;
#(
  parameter int CNT_W     = 5,
  parameter int SHORT_MIN = 7,
  parameter int SHORT_MAX = 8,
  parameter int LONG_MIN  = 9,
  parameter int LONG_MAX  = 11,
  parameter int GRP0      = 7,
  parameter int GRP1      = 6,
  parameter int MAX_RUN   = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              carrier_i,
  input  logic              single_i,
  input  logic              restart_i,
  output logic              valid_o,
  output logic              done_o,
  output logic [WORD_W-1:0] word_hi_o,
  output logic [WORD_W-1:0] word_lo_o,
  output logic [VER_W-1:0]  version_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [NUM_W-1:0]  number_o
);
  localparam int MIN_G    = (GRP0 < GRP1) ? GRP0 : GRP1;
  localparam int MAX_BITS = (2 * MAX_RUN + MIN_G) / (2 * MIN_G);
  localparam int NB_W     = $clog2(MAX_BITS + 1);

  logic               sym_v;
  sym_e               sym;
  logic               bits_v, bits_val, abort;
  logic [NB_W-1:0]    bits_n;
  logic [FRAME_W-1:0] frame;

  fsk_period_meter #(
    .CNT_W(CNT_W), .SHORT_MIN(SHORT_MIN), .SHORT_MAX(SHORT_MAX),
    .LONG_MIN(LONG_MIN), .LONG_MAX(LONG_MAX)
  ) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .carrier_i(carrier_i),
    .sym_v_o(sym_v), .sym_o(sym)
  );

  fsk_run_binner #(
    .GRP0(GRP0), .GRP1(GRP1), .MAX_RUN(MAX_RUN), .NB_W(NB_W)
  ) u_binner (
    .clk_i(clk_i), .rst_ni(rst_ni), .sym_v_i(sym_v), .sym_i(sym),
    .bits_v_o(bits_v), .bits_n_o(bits_n), .bits_val_o(bits_val), .abort_o(abort)
  );

  fsk_frame_capture #(
    .MAX_BITS(MAX_BITS), .NB_W(NB_W)
  ) u_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .bits_v_i(bits_v), .bits_n_i(bits_n),
    .bits_val_i(bits_val), .abort_i(abort), .single_i(single_i),
    .restart_i(restart_i), .frame_o(frame), .valid_o(valid_o), .done_o(done_o)
  );

  // frame offset k sits at frame[FRAME_W-1-k]
  assign word_hi_o = frame[FRAME_W-1 -: WORD_W];
  assign word_lo_o = frame[WORD_W-1:0];
  assign version_o = frame[FRAME_W-1-VER_OFF -: VER_W];
  assign tag_o     = frame[FRAME_W-1-TAG_OFF -: TAG_W];
  assign number_o  = frame[FRAME_W-1-NUM_OFF -: NUM_W];
endmodule

// File: rtl/fsk_frame_decoder_chk.sv
module fsk_frame_decoder_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        single_i,
  input logic        restart_i,
  input logic        valid_o,
  input logic        done_o,
  input logic [31:0] word_hi_o,
  input logic [31:0] word_lo_o,
  input logic        bits_v
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R7
  AST_WORDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(word_hi_o) && $stable(word_lo_o))); // R7
  AST_VALID_AFTER_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bits_v)); // R8
  AST_DONE_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (valid_o && $past(single_i))); // R9
  AST_DONE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> !valid_o); // R9
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !restart_i) |=> done_o); // R9
endmodule

bind fsk_frame_decoder fsk_frame_decoder_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .single_i(single_i), .restart_i(restart_i),
  .valid_o(valid_o), .done_o(done_o), .word_hi_o(word_hi_o),
  .word_lo_o(word_lo_o), .bits_v(bits_v)
);

// File: tb/fsk_frame_decoder_bench.sv
module fsk_frame_decoder_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        carrier_i = 1'b0;
  logic        single_i = 1'b0;
  logic        restart_i = 1'b0;
  logic        valid_o, done_o;
  logic [31:0] word_hi_o, word_lo_o;
  logic [3:0]  version_o;
  logic [7:0]  tag_o;
  logic [8:0]  number_o;

  int n_chk = 0, n_fail = 0;
  int tick = 0, vcount = 0, last_tick = -1, rise_tick = 0;
  logic [31:0] hi_s = '0, lo_s = '0;
  logic [3:0]  ver_s = '0;
  logic [7:0]  tag_s = '0;
  logic [8:0]  num_s = '0;
  logic        done_s = 1'b0;

  always #4 clk_i = ~clk_i;

  fsk_frame_decoder u_fsk_frame_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .carrier_i(carrier_i), .single_i(single_i),
    .restart_i(restart_i), .valid_o(valid_o), .done_o(done_o),
    .word_hi_o(word_hi_o), .word_lo_o(word_lo_o), .version_o(version_o),
    .tag_o(tag_o), .number_o(number_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: sample outputs at the falling edge, then drive the carrier
  task automatic step(input bit v);
    @(negedge clk_i);
    tick++;
    if (valid_o) begin
      vcount++;
      last_tick = tick;
      hi_s = word_hi_o; lo_s = word_lo_o;
      ver_s = version_o; tag_s = tag_o; num_s = number_o; done_s = done_o;
    end
    carrier_i = v;
  endtask

  task automatic cyc(input int p);
    for (int i = 0; i < p; i++) begin
      step(i < p / 2);
      if (i == 0) rise_tick = tick;
    end
  endtask

  task automatic run(input bit b, input int n, input int ps, input int pl);
    for (int i = 0; i < n; i++) cyc(b ? pl : ps);
  endtask

  function automatic logic [63:0] mk(input int seed);
    logic [31:0] r;
    logic [63:0] f;
    bit prev, b;
    int rl;
    r = 32'h1234_5678 ^ (32'(seed) * 32'h9E37_79B9);
    f = 64'h0040_0000_0000_0000;
    prev = 1'b1;
    rl = 1;
    for (int j = 53; j >= 0; j--) begin
      b = r[0];
      r = {r[30:0], r[31] ^ r[21] ^ r[1] ^ r[0]};
      if (b == prev && rl == 8) b = ~prev;
      if (b == prev) rl++;
      else begin rl = 1; prev = b; end
      f[j] = b;
    end
    return f;
  endfunction

  function automatic logic [31:0] getf(input logic [63:0] f, input int off, input int w);
    logic [31:0] v = '0;
    for (int j = 0; j < w; j++) v = {v[30:0], f[63 - off - j]};
    return v;
  endfunction

  task automatic send(input logic [63:0] f, input int ps, input int pl, input int d0,
                      input int d1, input bit sat, input int cut, input int cutp,
                      output int flush);
    int i, k, n, used;
    bit b;
    cyc(15);
    run(1'b1, 6, ps, pl);
    i = 63;
    used = 0;
    while (i >= 0) begin
      b = f[i];
      k = 0;
      while (i >= 0 && f[i] == b) begin k++; i--; end
      n = b ? 6 * k + d1 : 7 * k + d0;
      if (sat && !b && k == 9) n = 70;
      run(b, n, ps, pl);
      used += k;
      if (cut > 0 && used >= cut) begin cyc(cutp); cut = 0; end
    end
    b = ~f[0];
    cyc(b ? pl : ps);
    cyc(b ? pl : ps);
    flush = rise_tick;
    repeat (4) cyc(b ? pl : ps);
    cyc(15);
    cyc(8);
  endtask

  task automatic expect_frame(input logic [63:0] f, input int vc0, input int flush,
                              input string tc);
    chk(vcount == vc0 + 1, "R7", {tc, " strobe count"}, 64'(vcount - vc0), 64'd1);
    chk(last_tick == flush + 3, "R8", {tc, " latency"}, 64'(last_tick), 64'(flush + 3));
    chk(hi_s == getf(f, 0, 32), "R4 R5", {tc, " word_hi"}, 64'(hi_s), 64'(getf(f, 0, 32)));
    chk(lo_s == getf(f, 32, 32), "R5", {tc, " word_lo"}, 64'(lo_s), 64'(getf(f, 32, 32)));
    chk(32'(ver_s) == getf(f, 14, 4), "R6", {tc, " version"}, 64'(ver_s), 64'(getf(f, 14, 4)));
    chk(32'(tag_s) == getf(f, 19, 8), "R6", {tc, " tag"}, 64'(tag_s), 64'(getf(f, 19, 8)));
    chk(32'(num_s) == getf(f, 36, 9), "R6", {tc, " number"}, 64'(num_s), 64'(getf(f, 36, 9)));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int fl, vc0;
    logic [63:0] f, keep;
    repeat (3) step(1'b0);
    chk(!valid_o && !done_o && word_hi_o == 0 && word_lo_o == 0 && version_o == 0
        && tag_o == 0 && number_o == 0, "R10", "outputs in reset", 64'(word_hi_o), 64'd0);
    rst_ni = 1'b1;
    step(1'b0);
    chk(!valid_o && !done_o && word_lo_o == 0, "R10", "outputs after reset",
        64'({valid_o, done_o}), 64'd0);

    // R1 R2: nominal periods, period edges 7/11 and 8/9, run length offsets incl. half point
    for (int s = 0; s < 9; s++) begin
      f = mk(s);
      vc0 = vcount;
      case (s % 3)
        0:       send(f, 8, 10, 0, 0, 1'b0, 0, 0, fl);
        1:       send(f, 7, 11, 3, -3, 1'b0, 0, 0, fl);
        default: send(f, 8, 9, -3, 2, 1'b0, 0, 0, fl);
      endcase
      expect_frame(f, vc0, fl, $sformatf("R1 R2 frame %0d", s));
    end

    // R3: header zero run of 70 cycles saturates to 64 -> nine zero bits
    f = mk(10);
    vc0 = vcount;
    send(f, 8, 10, 0, 0, 1'b1, 0, 0, fl);
    expect_frame(f, vc0, fl, "R3 saturated header");

    // R1: out-of-range periods 6, 12, 15 abort a partial frame; outputs held
    keep = f;
    for (int a = 0; a < 3; a++) begin
      vc0 = vcount;
      send(mk(30 + a), 8, 10, 0, 0, 1'b0, 20 + 10 * a, (a == 0) ? 6 : (a == 1) ? 12 : 15, fl);
      chk(vcount == vc0, "R1", "aborted frame strobe", 64'(vcount - vc0), 64'd0);
      chk(word_hi_o == keep[63:32] && word_lo_o == keep[31:0], "R1 R7", "held words",
          {word_hi_o, word_lo_o}, keep);
    end

    // R9: single-capture mode
    single_i = 1'b1;
    f = mk(20);
    vc0 = vcount;
    send(f, 8, 10, 0, 0, 1'b0, 0, 0, fl);
    expect_frame(f, vc0, fl, "R9 single first");
    chk(done_s == 1'b1, "R9", "done with strobe", 64'(done_s), 64'd1);
    keep = f;
    vc0 = vcount;
    send(mk(21), 8, 10, 0, 0, 1'b0, 0, 0, fl);
    chk(vcount == vc0, "R9", "ignored after done", 64'(vcount - vc0), 64'd0);
    chk({word_hi_o, word_lo_o} == keep && done_o, "R9", "held after done",
        {word_hi_o, word_lo_o}, keep);
    restart_i = 1'b1;
    step(1'b0);
    restart_i = 1'b0;
    step(1'b0);
    chk(done_o == 1'b0, "R9", "restart clears done", 64'(done_o), 64'd0);
    f = mk(22);
    vc0 = vcount;
    send(f, 8, 10, 0, 0, 1'b0, 0, 0, fl);
    expect_frame(f, vc0, fl, "R9 after restart");
    chk(done_o == 1'b1, "R9", "done again", 64'(done_o), 64'd1);

    single_i = 1'b0;
    restart_i = 1'b1;
    step(1'b0);
    restart_i = 1'b0;
    for (int s = 0; s < 2; s++) begin
      f = mk(40 + s);
      vc0 = vcount;
      send(f, 8, 10, 0, 0, 1'b0, 0, 0, fl);
      expect_frame(f, vc0, fl, $sformatf("R9 continuous %0d", s));
      chk(done_o == 1'b0, "R9", "no done in continuous mode", 64'(done_o), 64'd0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule